// File: doc/BRIEF.md
# Codec Command Ring Fetcher

This block feeds 32-bit command words to a set of attached audio codecs. Software fills a circular ring of 256 command words in memory, then moves a write pointer forward. The fetcher reads each new word over a simple memory read port and splits it into codec address, node id and payload. It hands each command to the codec side through a valid/ready dispatch port. Words that ask for indirect node addressing are discarded, and so are words aimed at a codec address with no codec fitted.

Beside the ring there is a single-entry immediate slot. Software writes one command word into it and sets a busy flag. That command goes out ahead of any ring entry, and the busy flag drops once the command has been handed over or discarded. A stall input from the response side stops new ring fetches while the response-count threshold is reached. It has no effect on the immediate slot. Only one command is ever in flight between fetch and dispatch.

Top module: `cmd_ring_fetch`

## Requirements
- R1: While the immediate busy flag is set, no ring fetch begins; the immediate command is dispatched before any further ring entry.
- R2: A ring fetch begins only when the run bit (bit 0 of select 2) is 1 and the read pointer differs from the write pointer.
- R3: No ring fetch begins while `resp_stall` is high. The immediate slot is still served while it is high.
- R4: Each fetch reads address base + 4 × ((read pointer + 1) mod 256). The read pointer takes that new value when the word returns, so it wraps from 255 to 0.
- R5: A dispatched command carries codec address = verb[31:28], node id = verb[26:20] and payload = verb[19:0].
- R6: A verb with bit 27 set is never dispatched, but the read pointer still advances past it.
- R7: A verb whose codec address selects a clear bit of `codec_present` is dropped. This holds for ring entries and for the immediate slot, and a dropped immediate command clears the busy flag.
- R8: Register writes use `reg_sel`: 0 = ring base address, 1 = write pointer (bits 7:0), 2 = control (bit 0 = run), 3 = immediate command word, 4 = bit 0 written as 1 sets the busy flag. A write to the write pointer, to control, or a busy set is enough to start work, with no further action.
- R9: `disp_valid` stays high with stable fields until `disp_ready`. No memory request is issued while a command waits for dispatch.
- R10: A synchronous reset clears the read pointer, write pointer, run bit, busy flag and ring base, and leaves `mem_req` and `disp_valid` low.
- R11: The busy flag clears in the cycle the immediate command is accepted on the dispatch port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| codec_present | input | 16 | One bit per codec address, 1 = codec fitted |
| resp_stall | input | 1 | Response-count threshold reached, pause fetching |
| mem_req | output | 1 | Memory read request, held until `mem_rvalid` |
| mem_addr | output | 32 | Byte address of the requested ring word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| disp_valid | output | 1 | Command offered to the codec side |
| disp_ready | input | 1 | Codec side accepts the command |
| disp_cad | output | 4 | Codec address |
| disp_nid | output | 7 | Node id |
| disp_payload | output | 20 | Command payload |
| rd_ptr | output | 8 | Ring read pointer |
| imm_busy | output | 1 | Immediate command pending |

## Verification
The hardest case to reach from the ports is a collision: the immediate slot becomes pending while ring entries are already waiting. In an unstalled ring the fetcher drains the backlog before software can act. The stimulus holds `resp_stall` high, advances the write pointer so a backlog builds, then loads and arms the immediate slot. The immediate command must overtake the backlog, and the backlog must drain only after the stall is released. The pointer wrap is reached by walking the ring to entry 250 and then setting the write pointer past zero, with every request address checked across the boundary.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int VERB_W   = 32;
  localparam int CAD_W    = 4;
  localparam int NID_W    = 7;
  localparam int PAY_W    = 20;
  localparam int CAD_LSB  = 28;
  localparam int NID_LSB  = 20;
  localparam int INDIR_BIT = 27;
  localparam int NUM_CAD  = 1 << CAD_W;

  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_WPTR  = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_IMMW  = 3'd3,
    SEL_IMMGO = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SEND  = 2'd2
  } fetch_state_e;

  typedef struct packed {
    logic [CAD_W-1:0] cad;
    logic [NID_W-1:0] nid;
    logic [PAY_W-1:0] payload;
  } cmd_t;

  function automatic cmd_t split_verb(input logic [VERB_W-1:0] v);
    cmd_t c;
    c.cad     = v[CAD_LSB +: CAD_W];
    c.nid     = v[NID_LSB +: NID_W];
    c.payload = v[PAY_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/cmdring_cfg.sv
module cmdring_cfg
  import cmdring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic [ADDR_W-1:0] base_o,
  output logic [PTR_W-1:0]  wptr_o,
  output logic              run_o,
  output logic [VERB_W-1:0] imm_word_o,
  output logic              imm_set_o
);
  // a busy set is a one-cycle event, not a stored bit here
  assign imm_set_o = wr_en && (wr_sel == SEL_IMMGO) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o     <= '0;
      wptr_o     <= '0;
      run_o      <= 1'b0;
      imm_word_o <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_BASE: base_o     <= wr_data[ADDR_W-1:0];
        SEL_WPTR: wptr_o     <= wr_data[PTR_W-1:0];
        SEL_CTRL: run_o      <= wr_data[0];
        SEL_IMMW: imm_word_o <= wr_data[VERB_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmdring_verb_check.sv
module cmdring_verb_check
  import cmdring_pkg::*;
(
  input  logic [VERB_W-1:0]  verb,
  input  logic [NUM_CAD-1:0] present,
  output cmd_t               cmd,
  output logic               ok
);
  logic indirect;
  logic target_fitted;

  assign cmd           = split_verb(verb);
  assign indirect      = verb[INDIR_BIT];
  assign target_fitted = present[cmd.cad];
  assign ok            = !indirect && target_fitted;
endmodule

// File: rtl/cmdring_fetch_ctrl.sv
module cmdring_fetch_ctrl
  import cmdring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  base,
  input  logic [PTR_W-1:0]   wptr,
  input  logic               run,
  input  logic [VERB_W-1:0]  imm_word,
  input  logic               imm_set,
  input  logic               stall,
  input  logic [NUM_CAD-1:0] present,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [VERB_W-1:0]  mem_rdata,
  output logic               disp_valid,
  input  logic               disp_ready,
  output cmd_t               disp_cmd,
  output logic [PTR_W-1:0]   rd_ptr,
  output logic               busy
);
  localparam int WORD_SHIFT = 2;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [PTR_W-1:0]  p);
    return b + (ADDR_W'(p) << WORD_SHIFT);
  endfunction

  fetch_state_e      st;
  cmd_t              hold;
  logic              from_imm;
  logic [ADDR_W-1:0] addr_q;
  logic [PTR_W-1:0]  rp;
  logic              busy_q;

  logic [VERB_W-1:0] chk_verb;
  cmd_t              chk_cmd;
  logic              chk_ok;

  // one checker serves both sources: the ring word while fetching, else the slot
  assign chk_verb = (st == ST_FETCH) ? mem_rdata : imm_word;

  cmdring_verb_check u_chk (
    .verb    (chk_verb),
    .present (present),
    .cmd     (chk_cmd),
    .ok      (chk_ok)
  );

  // named events for the checks below
  logic ring_has_work, imm_take, fetch_start, fetch_done, send_done;
  assign ring_has_work = run && (rp != wptr);
  assign imm_take      = (st == ST_IDLE) && busy_q;
  assign fetch_start   = (st == ST_IDLE) && !busy_q && ring_has_work && !stall;
  assign fetch_done    = (st == ST_FETCH) && mem_rvalid;
  assign send_done     = (st == ST_SEND) && disp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      hold     <= '0;
      from_imm <= 1'b0;
      addr_q   <= '0;
      rp       <= '0;
      busy_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (imm_take) begin
            if (chk_ok) begin
              hold     <= chk_cmd;
              from_imm <= 1'b1;
              st       <= ST_SEND;
            end else begin
              busy_q <= 1'b0;
            end
          end else if (fetch_start) begin
            addr_q <= slot_addr(base, ptr_inc(rp));
            st     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fetch_done) begin
            rp <= ptr_inc(rp);
            if (chk_ok) begin
              hold     <= chk_cmd;
              from_imm <= 1'b0;
              st       <= ST_SEND;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_SEND: begin
          if (send_done) begin
            st <= ST_IDLE;
            if (from_imm) busy_q <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (imm_set) busy_q <= 1'b1;
    end
  end

  assign mem_req    = (st == ST_FETCH);
  assign mem_addr   = addr_q;
  assign disp_valid = (st == ST_SEND);
  assign disp_cmd   = hold;
  assign rd_ptr     = rp;
  assign busy       = busy_q;

  // R1
  imm_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(!busy_q));

  // R2
  fetch_needs_work_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(run && (rp != wptr)));

  // R3
  fetch_stall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(!stall));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_done |=> $stable(rd_ptr));

  // R6
  indirect_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_done && mem_rdata[INDIR_BIT]) |=> !disp_valid);

  // R9
  send_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_cmd)));

  // R9
  one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready) |=> !mem_req);
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import cmdring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic [15:0]       codec_present,
  input  logic              resp_stall,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [3:0]        disp_cad,
  output logic [6:0]        disp_nid,
  output logic [19:0]       disp_payload,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              imm_busy
);
  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  wptr;
  logic              run;
  logic [VERB_W-1:0] imm_word;
  logic              imm_set;
  cmd_t              cmd;

  cmdring_cfg #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .wr_sel     (reg_sel),
    .wr_data    (reg_wdata),
    .base_o     (base),
    .wptr_o     (wptr),
    .run_o      (run),
    .imm_word_o (imm_word),
    .imm_set_o  (imm_set)
  );

  cmdring_fetch_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .base       (base),
    .wptr       (wptr),
    .run        (run),
    .imm_word   (imm_word),
    .imm_set    (imm_set),
    .stall      (resp_stall),
    .present    (codec_present),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_cmd   (cmd),
    .rd_ptr     (rd_ptr),
    .busy       (imm_busy)
  );

  assign disp_cad     = cmd.cad;
  assign disp_nid     = cmd.nid;
  assign disp_payload = cmd.payload;
endmodule

// File: tb/cmd_ring_fetch_test.sv
`timescale 1ns/1ps
module cmd_ring_fetch_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [15:0] codec_present;
  logic        resp_stall;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        disp_valid;
  logic        disp_ready;
  logic [3:0]  disp_cad;
  logic [6:0]  disp_nid;
  logic [19:0] disp_payload;
  logic [7:0]  rd_ptr;
  logic        imm_busy;

  always #2.5 clk = ~clk;

  cmd_ring_fetch uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .codec_present(codec_present), .resp_stall(resp_stall),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_cad(disp_cad), .disp_nid(disp_nid), .disp_payload(disp_payload),
    .rd_ptr(rd_ptr), .imm_busy(imm_busy)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int disp_n = 0;
  logic [31:0] ring [256];
  logic [31:0] exp_q [$];
  int   sw_rp = 0;
  int   model_rp = 0;
  logic [31:0] base_v = 32'h0;
  bit   no_fetch = 1'b0;
  bit   ready_off = 1'b0;
  bit   req_seen = 1'b0;
  int   lat = 0;
  bit   pend = 1'b0;
  logic [30:0] pend_f;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic bit accepts(input logic [31:0] v);
    int cad;
    cad = int'(v >> 28);
    return (((v >> 27) & 1) == 0) && codec_present[cad];
  endfunction

  function automatic logic [31:0] gen(input int i);
    logic [31:0] v;
    v = ((i % 3) << 28) | (((i * 5) % 128) << 20) | ((i * 40503 + 17) & 32'hfffff);
    return v;
  endfunction

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic advance_wp(input int new_wp);
    while (sw_rp != new_wp) begin
      sw_rp = (sw_rp + 1) % 256;
      if (accepts(ring[sw_rp])) exp_q.push_back(ring[sw_rp]);
    end
    reg_write(3'd1, new_wp);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || mem_req || disp_valid) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8", "commands left undispatched", exp_q.size(), 0);
  endtask

  // memory responder, dispatch sink and per-cycle comparison against the model
  initial begin
    mem_rvalid = 1'b0; mem_rdata = '0; disp_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
      end else if (mem_req && !rst) begin
        if (!req_seen) begin
          req_seen = 1'b1;
          lat = cyc % 3;
          check(mem_addr == base_v + 32'(4 * ((model_rp + 1) % 256)), "R4",
                "fetch address", mem_addr, base_v + 32'(4 * ((model_rp + 1) % 256)));
        end
        if (lat == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = ring[((mem_addr - base_v) >> 2) & 32'hff];
          model_rp   = (model_rp + 1) % 256;
          req_seen   = 1'b0;
        end else begin
          lat--;
        end
      end
      if (no_fetch && mem_req)
        check(1'b0, "R2/R3", "fetch while blocked", 1, 0);
      disp_ready = ready_off ? 1'b0 : ((cyc % 4) != 1);
      #1;
      if (!rst) begin
        if (disp_valid && mem_req) check(1'b0, "R9", "request during dispatch", 1, 0);
        if (pend) begin
          check(disp_valid && ({disp_cad, disp_nid, disp_payload} == pend_f), "R9",
                "held command", {disp_valid, disp_cad, disp_nid, disp_payload},
                {1'b1, pend_f});
        end
        pend = disp_valid && !disp_ready;
        pend_f = {disp_cad, disp_nid, disp_payload};
        if (disp_valid && disp_ready) begin
          disp_n++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected dispatch", {disp_cad, disp_nid, disp_payload}, 0);
          end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check({disp_cad, disp_nid, disp_payload} == {e[31:28], e[26:20], e[19:0]},
                  "R5", "dispatched fields", {disp_cad, disp_nid, disp_payload},
                  {e[31:28], e[26:20], e[19:0]});
          end
        end
      end else begin
        pend = 1'b0;
      end
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    rst = 1'b1; reg_wr_en = 1'b0; reg_sel = '0; reg_wdata = '0;
    codec_present = 16'h0007; resp_stall = 1'b0;
    for (int i = 0; i < 256; i++) ring[i] = gen(i);
    ring[4] = gen(4) | 32'h0800_0000;          // indirect flag
    ring[5] = (gen(5) & 32'h07ff_ffff) | 32'h9000_0000; // no codec at 9
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(rd_ptr == 0, "R10", "rd_ptr after reset", rd_ptr, 0);
    check(imm_busy == 0, "R10", "busy after reset", imm_busy, 0);
    check(!mem_req && !disp_valid, "R10", "idle outputs", {mem_req, disp_valid}, 0);

    // R2: ring filled but run clear
    base_v = 32'h0000_4000;
    reg_write(3'd0, base_v);
    no_fetch = 1'b1;
    advance_wp(3);
    repeat (20) @(negedge clk);
    check(rd_ptr == 0, "R2", "rd_ptr with run clear", rd_ptr, 0);
    no_fetch = 1'b0;

    // R8: control write starts the ring
    reg_write(3'd2, 32'h1);
    drain();
    check(rd_ptr == 3, "R4", "rd_ptr after three entries", rd_ptr, 3);
    check(disp_n == 3, "R8", "dispatch count", disp_n, 3);

    // R6 R7: indirect and absent-codec entries dropped, pointer still moves
    advance_wp(6);
    drain();
    check(rd_ptr == 6, "R6", "rd_ptr past dropped entries", rd_ptr, 6);
    check(disp_n == 4, "R7", "only one of three dispatched", disp_n, 4);

    // R3 and R1: backlog held by stall, immediate overtakes it
    resp_stall = 1'b1;
    no_fetch = 1'b1;
    advance_wp(8);
    repeat (15) @(negedge clk);
    check(rd_ptr == 6, "R3", "rd_ptr while stalled", rd_ptr, 6);
    v = 32'h1234_5678 & 32'hf7ff_ffff;
    v = (v & 32'h0fff_ffff) | 32'h1000_0000;
    reg_write(3'd3, v);
    exp_q.push_front(v);
    reg_write(3'd4, 32'h1);
    repeat (10) @(negedge clk);
    check(imm_busy == 0, "R11", "busy after immediate accepted", imm_busy, 0);
    check(exp_q.size() == 2, "R1", "backlog untouched, immediate served", exp_q.size(), 2);
    no_fetch = 1'b0;
    resp_stall = 1'b0;
    drain();
    check(rd_ptr == 8, "R3", "backlog drained after stall", rd_ptr, 8);

    // R7: immediate to an absent codec is dropped and busy clears
    n0 = disp_n;
    reg_write(3'd3, 32'hc012_3456);
    reg_write(3'd4, 32'h1);
    repeat (6) @(negedge clk);
    check(imm_busy == 0, "R7", "busy after dropped immediate", imm_busy, 0);
    check(disp_n == n0, "R7", "no dispatch for absent codec", disp_n, n0);

    // R8: writing zero to the busy register does nothing
    reg_write(3'd4, 32'h0);
    repeat (4) @(negedge clk);
    check(imm_busy == 0 && disp_n == n0, "R8", "busy write of zero", {imm_busy, 8'(disp_n)}, {1'b0, 8'(n0)});

    // R4 wrap from 255 to 0
    advance_wp(250);
    drain();
    check(rd_ptr == 250, "R4", "rd_ptr before wrap", rd_ptr, 250);
    advance_wp(3);
    drain();
    check(rd_ptr == 3, "R4", "rd_ptr after wrap", rd_ptr, 3);

    // R10: reset with an immediate held at the dispatch port
    ready_off = 1'b1;
    reg_write(3'd3, 32'h2001_0001);
    exp_q.push_back(32'h2001_0001);
    reg_write(3'd4, 32'h1);
    repeat (5) @(negedge clk);
    check(imm_busy == 1 && disp_valid == 1, "R9", "immediate held without ready",
          {imm_busy, disp_valid}, 2'b11);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    sw_rp = 0; model_rp = 0; base_v = 0; ready_off = 1'b0;
    @(negedge clk);
    check(imm_busy == 0 && !disp_valid, "R10", "busy and dispatch cleared",
          {imm_busy, disp_valid}, 0);
    check(rd_ptr == 0, "R10", "rd_ptr cleared", rd_ptr, 0);
    no_fetch = 1'b1;
    reg_write(3'd1, 32'd4);
    repeat (20) @(negedge clk);
    check(rd_ptr == 0, "R10", "run cleared by reset", rd_ptr, 0);
    no_fetch = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule